// File: doc/BRIEF.md
# Byte-Register Bus Bridge

This block gives a host that can only reach byte-wide registers a way to run single 32-bit cycles on an internal memory-mapped bus. The host writes the target address four bytes at a time. For a write it also fills a four-byte data buffer. It then picks an access size and fires the cycle through a trigger register.

Writing one magic value to the trigger register launches a bus write. Reading the trigger register launches a bus read. When the bus answers, the returned word becomes readable byte by byte from the same data registers. In every multi-byte field, the lowest register offset carries the most significant byte.

On the bus side the block is a single-beat master. It raises a valid signal and holds the request until the slave returns ready. A busy flag covers the whole time between trigger and handshake.

Top module: `byte_bus_bridge`

## Requirements
- R1: After reset, busy and busValid are 0. The enable, address and data registers read back 0, and the size register at 0xF8 reads back 2.
- R2: Bit 0 of register 0x30 enables the bridge and reads back at bit 0. While it is 0, neither trigger form starts a cycle.
- R3: Registers 0xF0, 0xF1, 0xF2 and 0xF3 hold address bits [31:24], [23:16], [15:8] and [7:0]. They read back as written and drive busAddr.
- R4: Registers 0xF4, 0xF5, 0xF6 and 0xF7 hold data bits [31:24], [23:16], [15:8] and [7:0]. Data written there reads back as written and drives busWdata.
- R5: Register 0xF8 bits [1:0] select the size, and reads back those bits with zeros above them. Size 0 gives busStrb 4'b0001, and busWdata carries only bits [7:0] with the upper bits zero. Size 1 gives 4'b0011, carrying bits [15:0]. Size 2 or 3 gives 4'b1111, carrying all 32 bits.
- R6: Writing 0xCF to 0xFE while the bridge is enabled and idle raises busValid with busWrite=1 from the next cycle. The request holds until the cycle in which busReady is 1.
- R7: A write to 0xFE with any value other than 0xCF starts no cycle.
- R8: A read of 0xFE while the bridge is enabled and idle raises busValid with busWrite=0 from the next cycle. On the handshake, the data registers load busRdata, keeping only the low-order bytes the size selects and clearing the rest.
- R9: busy is 1 from the cycle after a trigger through the handshake cycle, and reads back as bit 0 of 0xFE. While busy, triggers and all host register writes are ignored, and the data registers do not change before busReady.
- R10: While busValid is 1 and busReady is 0, busAddr, busWdata, busStrb and busWrite stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Host byte register write strobe |
| regRe | input | 1 | Host byte register read strobe |
| regAddr | input | 8 | Host register offset |
| regWdata | input | 8 | Host write byte |
| regRdata | output | 8 | Read-back byte for regAddr |
| busy | output | 1 | A bus cycle is outstanding |
| busValid | output | 1 | Bus request valid |
| busWrite | output | 1 | 1 for a write cycle, 0 for a read cycle |
| busAddr | output | 32 | Bus address |
| busWdata | output | 32 | Bus write data |
| busStrb | output | 4 | Byte-lane strobes, bit 0 for bits [7:0] |
| busReady | input | 1 | Slave completes the cycle |
| busRdata | input | 32 | Slave read data, sampled when busReady is 1 |

## Verification
The bench aims at several corner cases. It fires triggers with the enable bit clear, and writes wrong trigger values. Either would show up as a spurious busValid if the trigger decode ignored the enable or the value. It rewrites the data buffer and re-fires triggers in the middle of a slow cycle. A design that let host writes through while busy would corrupt busWdata or restart the request. It reads back in narrow sizes: a design that mapped the byte order the wrong way round, or that failed to clear the unused upper bytes, would return the wrong bytes at 0xF4..0xF7. Slave latencies of zero and several cycles check that the result is captured only on the handshake edge.

// File: rtl/bbb_pkg.sv
package bbb_pkg;
  localparam int DATA_BYTES = 4;
  localparam int BUS_W      = 8 * DATA_BYTES;
  localparam int SIZE_W     = 2;

  localparam logic [7:0] REG_ENABLE = 8'h30;
  localparam logic [7:0] REG_ADDR0  = 8'hF0;
  localparam logic [7:0] REG_DATA0  = 8'hF4;
  localparam logic [7:0] REG_SIZE   = 8'hF8;
  localparam logic [7:0] REG_TRIG   = 8'hFE;
  localparam logic [7:0] TRIG_MAGIC = 8'hCF;
  localparam logic [SIZE_W-1:0] SIZE_RESET = 2'd2;

  typedef struct packed {
    logic                  setEnable;
    logic [DATA_BYTES-1:0] loadAddr;
    logic [DATA_BYTES-1:0] loadData;
    logic                  loadSize;
    logic                  captureRd;
  } ctrlStrobes_t;

  // Byte lanes enabled by a size code; lane 0 is bits [7:0].
  function automatic logic [DATA_BYTES-1:0] laneMask(input logic [SIZE_W-1:0] sz);
    case (sz)
      2'd0:    return DATA_BYTES'(1);
      2'd1:    return DATA_BYTES'(3);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/bbb_ctrl.sv
module bbb_ctrl
  import bbb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWe,
  input  logic         regRe,
  input  logic [7:0]   regAddr,
  input  logic [7:0]   regWdata,
  input  logic         enable,
  input  logic         busReady,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         busWrite
);
  logic hostWr;
  logic wrTrig;
  logic rdTrig;

  assign hostWr = regWe && !busy;
  assign wrTrig = hostWr && enable && (regAddr == REG_TRIG) && (regWdata == TRIG_MAGIC);
  assign rdTrig = regRe && !regWe && !busy && enable && (regAddr == REG_TRIG);

  always_comb begin
    strobes           = '0;
    strobes.setEnable = hostWr && (regAddr == REG_ENABLE);
    strobes.loadSize  = hostWr && (regAddr == REG_SIZE);
    strobes.captureRd = busy && busReady && !busWrite;
    for (int i = 0; i < DATA_BYTES; i++) begin
      strobes.loadAddr[i] = hostWr && (regAddr == REG_ADDR0 + 8'(i));
      strobes.loadData[i] = hostWr && (regAddr == REG_DATA0 + 8'(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      busWrite <= 1'b0;
    end else if (busy) begin
      if (busReady) busy <= 1'b0;
    end else if (wrTrig || rdTrig) begin
      busy     <= 1'b1;
      busWrite <= wrTrig;
    end
  end
endmodule

// File: rtl/bbb_datapath.sv
module bbb_datapath
  import bbb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [7:0]         regAddr,
  input  logic [7:0]         regWdata,
  input  logic               busy,
  input  logic [BUS_W-1:0]   busRdata,
  output logic               enable,
  output logic [7:0]         regRdata,
  output logic [BUS_W-1:0]   busAddr,
  output logic [BUS_W-1:0]   busWdata,
  output logic [DATA_BYTES-1:0] busStrb
);
  logic [BUS_W-1:0]  addrReg;
  logic [BUS_W-1:0]  dataReg;
  logic [SIZE_W-1:0] sizeReg;
  logic [BUS_W-1:0]  bitMask;
  logic [BUS_W-1:0]  rdMasked;

  assign busStrb = laneMask(sizeReg);

  generate
    for (genvar j = 0; j < DATA_BYTES; j++) begin : g_lane
      assign bitMask[8*j +: 8] = {8{busStrb[j]}};
    end
  endgenerate

  assign rdMasked = busRdata & bitMask;
  assign busWdata = dataReg & bitMask;
  assign busAddr  = addrReg;

  // Register offset i holds the byte at lane DATA_BYTES-1-i (most significant first).
  generate
    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_byte
      localparam int HI = BUS_W - 1 - 8 * i;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          addrReg[HI -: 8] <= '0;
          dataReg[HI -: 8] <= '0;
        end else begin
          if (strobes.loadAddr[i]) addrReg[HI -: 8] <= regWdata;
          if (strobes.captureRd)       dataReg[HI -: 8] <= rdMasked[HI -: 8];
          else if (strobes.loadData[i]) dataReg[HI -: 8] <= regWdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      sizeReg <= SIZE_RESET;
    end else begin
      if (strobes.setEnable) enable  <= regWdata[0];
      if (strobes.loadSize)  sizeReg <= regWdata[SIZE_W-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == REG_ENABLE) regRdata = {7'b0, enable};
    if (regAddr == REG_SIZE)   regRdata = 8'(sizeReg);
    if (regAddr == REG_TRIG)   regRdata = {7'b0, busy};
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (regAddr == REG_ADDR0 + 8'(i)) regRdata = addrReg[BUS_W - 1 - 8 * i -: 8];
      if (regAddr == REG_DATA0 + 8'(i)) regRdata = dataReg[BUS_W - 1 - 8 * i -: 8];
    end
  end
endmodule

// File: rtl/byte_bus_bridge.sv
module byte_bus_bridge
  import bbb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic                  regRe,
  input  logic [7:0]            regAddr,
  input  logic [7:0]            regWdata,
  output logic [7:0]            regRdata,
  output logic                  busy,
  output logic                  busValid,
  output logic                  busWrite,
  output logic [BUS_W-1:0]      busAddr,
  output logic [BUS_W-1:0]      busWdata,
  output logic [DATA_BYTES-1:0] busStrb,
  input  logic                  busReady,
  input  logic [BUS_W-1:0]      busRdata
);
  ctrlStrobes_t strobes;
  logic         enable;

  bbb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regRe    (regRe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .enable   (enable),
    .busReady (busReady),
    .strobes  (strobes),
    .busy     (busy),
    .busWrite (busWrite)
  );

  bbb_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .busy     (busy),
    .busRdata (busRdata),
    .enable   (enable),
    .regRdata (regRdata),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busStrb  (busStrb)
  );

  assign busValid = busy;
endmodule

// File: rtl/bbb_checker.sv
module bbb_checker
  import bbb_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWe,
  input logic                  regRe,
  input logic [7:0]            regAddr,
  input logic [7:0]            regWdata,
  input logic                  enable,
  input logic                  busValid,
  input logic                  busWrite,
  input logic [BUS_W-1:0]      busAddr,
  input logic [BUS_W-1:0]      busWdata,
  input logic [DATA_BYTES-1:0] busStrb,
  input logic                  busReady,
  input logic [7:0]            dataByte0
);
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !busValid) |=> !busValid); // R2

  AST_WRITE_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !busValid && regWe && regAddr == REG_TRIG && regWdata == TRIG_MAGIC)
      |=> (busValid && busWrite)); // R6

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> busValid); // R6

  AST_BAD_MAGIC: assert property (@(posedge clk) disable iff (!rstN)
    (!busValid && regWe && regAddr == REG_TRIG && regWdata != TRIG_MAGIC) |=> !busValid); // R7

  AST_READ_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !busValid && regRe && !regWe && regAddr == REG_TRIG)
      |=> (busValid && !busWrite)); // R8

  AST_STRB_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busStrb == 4'b0001 || busStrb == 4'b0011 || busStrb == 4'b1111)); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> $stable(dataByte0)); // R9

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> ($stable(busAddr) && $stable(busWdata)
                                 && $stable(busStrb) && $stable(busWrite))); // R10
endmodule

bind byte_bus_bridge bbb_checker u_bbb_checker (
  .clk       (clk),
  .rstN      (rstN),
  .regWe     (regWe),
  .regRe     (regRe),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .enable    (enable),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busStrb   (busStrb),
  .busReady  (busReady),
  .dataByte0 (u_dp.dataReg[31:24])
);

// File: tb/byte_bus_bridge_bench.sv
module byte_bus_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [7:0]  regWdata = 8'h00;
  logic [7:0]  regRdata;
  logic        busy, busValid, busWrite;
  logic [31:0] busAddr, busWdata;
  logic [3:0]  busStrb;
  logic        busReady = 1'b0;
  logic [31:0] busRdata = 32'h0;

  int nChecks = 0;
  int nErrors = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  byte_bus_bridge u_byte_bus_bridge (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata), .busStrb(busStrb),
    .busReady(busReady), .busRdata(busRdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- bus slave ----------------
  logic [31:0] mem [logic [31:0]];
  int slaveLat = 2;
  int slaveCnt = 0;

  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'hA5C3_5A3C;
  endfunction

  always @(negedge clk) begin
    if (!busValid) begin
      busReady = 1'b0;
      slaveCnt = 0;
    end else if (slaveCnt >= slaveLat) begin
      busReady = 1'b1;
      busRdata = memRead(busAddr);
    end else begin
      slaveCnt++;
    end
  end

  always @(posedge clk) begin
    if (rstN && busValid && busReady && busWrite) begin
      logic [31:0] old;
      old = memRead(busAddr);
      for (int k = 0; k < 4; k++)
        if (busStrb[k]) old[8*k +: 8] = busWdata[8*k +: 8];
      mem[busAddr] = old;
    end
  end

  // ---------------- reference model ----------------
  bit          enM;
  logic [31:0] addrM, dataM;
  logic [1:0]  sizeM;
  bit          busyM, wrM;

  function automatic logic [31:0] keepLow(input logic [31:0] v, input logic [1:0] sz);
    if (sz == 2'd0) return v & 32'h0000_00FF;
    if (sz == 2'd1) return v & 32'h0000_FFFF;
    return v;
  endfunction

  function automatic logic [3:0] strbFor(input logic [1:0] sz);
    if (sz == 2'd0) return 4'b0001;
    if (sz == 2'd1) return 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [7:0] readback(input logic [7:0] a);
    if (a == 8'h30) return {7'b0, enM};
    if (a >= 8'hF0 && a <= 8'hF3) return addrM[31 - 8*(a - 8'hF0) -: 8];
    if (a >= 8'hF4 && a <= 8'hF7) return dataM[31 - 8*(a - 8'hF4) -: 8];
    if (a == 8'hF8) return {6'b0, sizeM};
    if (a == 8'hFE) return {7'b0, busyM};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      enM = 0; addrM = 0; dataM = 0; sizeM = 2'd2; busyM = 0; wrM = 0;
    end else if (busyM) begin
      if (busReady) begin
        if (!wrM) dataM = keepLow(busRdata, sizeM);
        busyM = 0;
      end
    end else if (regWe) begin
      if (regAddr == 8'h30) enM = regWdata[0];
      if (regAddr >= 8'hF0 && regAddr <= 8'hF3) addrM[31 - 8*(regAddr - 8'hF0) -: 8] = regWdata;
      if (regAddr >= 8'hF4 && regAddr <= 8'hF7) dataM[31 - 8*(regAddr - 8'hF4) -: 8] = regWdata;
      if (regAddr == 8'hF8) sizeM = regWdata[1:0];
      if (regAddr == 8'hFE && enM && regWdata == 8'hCF) begin busyM = 1; wrM = 1; end
    end else if (regRe && regAddr == 8'hFE && enM) begin
      busyM = 1; wrM = 0;
    end
  end

  // Compare every cycle, away from both edges.
  always begin
    @(negedge clk);
    #2;
    if (running) begin
      chk("R9 busy", 32'(busy), 32'(busyM));
      chk("R6 busValid", 32'(busValid), 32'(busyM));
      if (busyM) chk("R8 busWrite", 32'(busWrite), 32'(wrM));
      chk("R3 busAddr", busAddr, addrM);
      chk("R4 busWdata", busWdata, keepLow(dataM, sizeM));
      chk("R5 busStrb", 32'(busStrb), 32'(strbFor(sizeM)));
      chk("R3 readback", 32'(regRdata), 32'(readback(regAddr)));
    end
  end

  // ---------------- host tasks ----------------
  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic loadWord(input logic [7:0] base, input logic [31:0] w);
    for (int i = 0; i < 4; i++) hostWrite(base + 8'(i), w[31 - 8*i -: 8]);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
    chk("R9 cycle completes", 32'(busy), 32'd0);
  endtask

  task automatic readWord(output logic [31:0] w);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      hostRead(8'hF4 + 8'(i), b);
      w[31 - 8*i -: 8] = b;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;

    // R1 reset values
    hostRead(8'h30, b); chk("R1 enable reset", 32'(b), 32'h0);
    hostRead(8'hF8, b); chk("R1 size reset", 32'(b), 32'h2);
    hostRead(8'hF4, b); chk("R1 data reset", 32'(b), 32'h0);
    chk("R1 busValid reset", 32'(busValid), 32'h0);

    // R2 triggers while disabled
    hostWrite(8'hFE, 8'hCF);
    chk("R2 write trigger disabled", 32'(busValid), 32'h0);
    hostRead(8'hFE, b);
    @(negedge clk); #1;
    chk("R2 read trigger disabled", 32'(busValid), 32'h0);

    // R3 R4 load address and data
    hostWrite(8'h30, 8'h01);
    hostRead(8'h30, b); chk("R2 enable readback", 32'(b), 32'h1);
    loadWord(8'hF0, 32'h1234_5678);
    loadWord(8'hF4, 32'hDEAD_BEEF);
    hostRead(8'hF0, b); chk("R3 addr msb byte", 32'(b), 32'h12);
    hostRead(8'hF3, b); chk("R3 addr lsb byte", 32'(b), 32'h78);
    hostRead(8'hF7, b); chk("R4 data lsb byte", 32'(b), 32'hEF);
    #1 chk("R3 busAddr value", busAddr, 32'h1234_5678);

    // R7 wrong magic
    hostWrite(8'hFE, 8'h55);
    #1 chk("R7 wrong magic ignored", 32'(busValid), 32'h0);

    // R6 write launch, slow slave, R9 activity while busy
    slaveLat = 4;
    hostWrite(8'hFE, 8'hCF);
    #1 chk("R6 write valid", 32'(busValid), 32'h1);
    chk("R6 write direction", 32'(busWrite), 32'h1);
    chk("R4 write data", busWdata, 32'hDEAD_BEEF);
    hostWrite(8'hF4, 8'h00);
    hostRead(8'hFE, b); chk("R9 busy readback", 32'(b), 32'h1);
    waitIdle();
    hostRead(8'hF4, b); chk("R9 write while busy ignored", 32'(b), 32'hDE);

    // R8 read back the word just written
    dataM = dataM; // model tracks independently
    loadWord(8'hF4, 32'h0);
    hostRead(8'hFE, b);
    #1 chk("R8 read launched", 32'(busValid), 32'h1);
    chk("R8 read direction", 32'(busWrite), 32'h0);
    waitIdle();
    readWord(w); chk("R8 read result", w, 32'hDEAD_BEEF);

    // R5 size 0 write, zero latency
    slaveLat = 0;
    hostWrite(8'hF8, 8'h00);
    loadWord(8'hF0, 32'h0000_0100);
    loadWord(8'hF4, 32'h1122_3344);
    #1 chk("R5 byte strobe", 32'(busStrb), 32'h1);
    chk("R5 byte wdata", busWdata, 32'h0000_0044);
    hostWrite(8'hFE, 8'hCF);
    waitIdle();

    // R8 size 1 read keeps low half only
    hostWrite(8'hF8, 8'h01);
    loadWord(8'hF0, 32'h1234_5678);
    hostRead(8'hFE, b);
    waitIdle();
    readWord(w); chk("R8 half read masked", w, 32'h0000_BEEF);
    #1 chk("R5 half strobe", 32'(busStrb), 32'h3);

    // R5 size 3 acts as full word; R9 retrigger during busy
    slaveLat = 3;
    hostWrite(8'hF8, 8'h03);
    hostRead(8'hF8, b); chk("R5 size readback", 32'(b), 32'h3);
    loadWord(8'hF0, 32'h0000_0100);
    hostRead(8'hFE, b);
    hostWrite(8'hFE, 8'hCF);
    #1 chk("R9 retrigger keeps read", 32'(busWrite), 32'h0);
    waitIdle();
    readWord(w); chk("R8 merged byte read", w, 32'hA5C3_5B44);

    // R2 disabled again
    hostWrite(8'h30, 8'h00);
    hostRead(8'hFE, b);
    @(negedge clk); #1;
    chk("R2 read trigger after disable", 32'(busValid), 32'h0);

    repeat (3) @(negedge clk);
    running = 1'b0;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule